// File: doc/BRIEF.md
# Multi-Source Configurable Pin Port

This block is an eight-pin bidirectional port inside a programmable logic device. A microcontroller configures it through a small register file. Every pin has three possible sources for the value it drives. The first is a data register that the microcontroller writes. The second is one byte of an address that is captured by the address-latch-enable strobe. The third is an output bit from an internal logic macrocell.

A pin's output enable comes from a direction register. When the pin is sourced from its macrocell, the enable instead comes from a per-pin enable product term that the internal logic supplies. The upper half of the pins can be set to open-drain operation, in which a pin drives only a low level. The lower half can be set to fast slew rate.

The pads are brought out as separate value, enable and level signals rather than as bidirectional nets. The pin levels are routed back out to the input macrocells. The microcontroller can also read the pin levels, the effective enables and most of the configuration.

Top module: `pinport_top`

## Requirements
- R1: After reset every register is 0. Every pin is therefore undriven (`padOe` = 0) and is sourced from the data-out register, and reads of offsets 1 to 7 return 0.
- R2: A pin whose source bit is 0 (offset 1) drives bit i of the data-out register (offset 2). Its enable is bit i of the direction register (offset 3).
- R3: A pin whose source bit is 1 and whose alternate-kind bit (offset 6) is 1 drives bit i of the selected address byte. Its enable still comes from the direction register.
- R4: A pin whose source bit is 1 and whose alternate-kind bit is 0 drives `mcellOut[i]`. Its enable is `ptermOe[i]`, and the direction register has no effect on that pin.
- R5: While `ale` is 1 the address is passed through in the same cycle. After `ale` drops, the port keeps the address that was on `addrBus` at the last clock edge at which `ale` was 1. Later changes on `addrBus` are ignored.
- R6: Bit 0 of offset 7 picks the address byte. A value of 0 selects `addrBus[7:0]` and a value of 1 selects `addrBus[15:8]`.
- R7: For pins 7 to 4, setting bit i of the drive register (offset 4) makes the pin open-drain. The pin is then enabled only while its selected value is 0. Drive bits 3 to 0 have no effect on any enable.
- R8: `padFastSlew[i]` equals drive bit i for pins 3 to 0. For pins 7 to 4 it is always 0.
- R9: A read of offset 5 returns the effective per-pin enable, which is the same as `padOe`.
- R10: Offsets 1, 2, 3, 4 and 6 read back the last value written. Offset 7 reads back only bit 0 and the other bits read 0. Offset 0 returns `padIn`. Reads are combinational from `regSel`.
- R11: Writes to offset 0 and offset 5 have no effect on any register or output.
- R12: `inMcell` always equals `padIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regSel | input | 3 | Register offset for both read and write |
| regWrEn | input | 1 | Write strobe, taken at the clock edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regSel` |
| ale | input | 1 | Address latch enable |
| addrBus | input | 16 | Address from the microcontroller |
| mcellOut | input | 8 | Macrocell output value per pin |
| ptermOe | input | 8 | Macrocell enable product term per pin |
| padIn | input | 8 | Level seen on each pin |
| padOut | output | 8 | Value driven on each pin |
| padOe | output | 8 | Effective per-pin output enable |
| padFastSlew | output | 8 | Fast slew request per pin |
| inMcell | output | 8 | Pin levels routed to the input macrocells |

## Verification
The bench builds the port with its default parameters: eight pins, a sixteen-bit address, and the open-drain and fast-slew halves split at pin 4. This puts every combination within reach. Each of the three sources can meet both enable origins, and the address byte select can flip while the latch is either open or holding. The drive register's two halves can also be set together, which shows that open-drain never leaks into the lower pins and slew never leaks into the upper ones. A modelled pull-up on released pins makes the read-back of pin levels depend on the effective enable.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

  // Register offsets; pin-level and enable readback are read-only
  typedef enum logic [2:0] {
    OFS_PIN_IN   = 3'd0,
    OFS_SRC_ALT  = 3'd1,
    OFS_DATA_OUT = 3'd2,
    OFS_DIR      = 3'd3,
    OFS_DRIVE    = 3'd4,
    OFS_EN_OUT   = 3'd5,
    OFS_ALT_KIND = 3'd6,
    OFS_ADDR_CFG = 3'd7
  } regOfs_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrSrcAlt;
    logic    wrDataOut;
    logic    wrDir;
    logic    wrDrive;
    logic    wrAltKind;
    logic    wrAddrCfg;
    logic    aleOpen;
    regOfs_e rdSel;
  } portStb_t;

endpackage

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
  import pinport_pkg::*;
(
  input  logic [2:0] regSel,
  input  logic       regWrEn,
  input  logic       ale,
  output portStb_t   stb
);

  regOfs_e ofs;

  assign ofs = regOfs_e'(regSel);

  always_comb begin
    stb           = '0;
    stb.rdSel     = ofs;
    stb.aleOpen   = ale;
    if (regWrEn) begin
      unique case (ofs)
        OFS_SRC_ALT:  stb.wrSrcAlt  = 1'b1;
        OFS_DATA_OUT: stb.wrDataOut = 1'b1;
        OFS_DIR:      stb.wrDir     = 1'b1;
        OFS_DRIVE:    stb.wrDrive   = 1'b1;
        OFS_ALT_KIND: stb.wrAltKind = 1'b1;
        OFS_ADDR_CFG: stb.wrAddrCfg = 1'b1;
        default: ; // read-only offsets swallow writes
      endcase
    end
  end

endmodule

// File: rtl/pinport_slice.sv
module pinport_slice #(
  parameter bit OD_OK = 1'b0  // 1: open-drain capable, 0: fast-slew capable
) (
  input  logic useAlt,
  input  logic altIsAddr,
  input  logic mcuBit,
  input  logic addrBit,
  input  logic mcellBit,
  input  logic dirBit,
  input  logic ptermBit,
  input  logic driveBit,
  output logic outBit,
  output logic oeBit,
  output logic fastBit
);

  logic value;
  logic baseOe;
  logic fromMcell;

  assign fromMcell = useAlt & ~altIsAddr;
  assign value     = useAlt ? (altIsAddr ? addrBit : mcellBit) : mcuBit;
  assign baseOe    = fromMcell ? ptermBit : dirBit;
  assign outBit    = value;

  generate
    if (OD_OK) begin : g_od
      assign oeBit   = baseOe & (~driveBit | ~value);
      assign fastBit = 1'b0;
    end else begin : g_slew
      assign oeBit   = baseOe;
      assign fastBit = driveBit;
    end
  endgenerate

endmodule

// File: rtl/pinport_dpath.sv
module pinport_dpath
  import pinport_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 16,
  parameter int OD_LO  = PIN_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  portStb_t          stb,
  input  logic [PIN_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [PIN_W-1:0]  mcellOut,
  input  logic [PIN_W-1:0]  ptermOe,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOe,
  output logic [PIN_W-1:0]  padFastSlew,
  output logic [PIN_W-1:0]  rdData,
  output logic [PIN_W-1:0]  driveCfg,
  output logic [PIN_W-1:0]  addrByte
);

  localparam int HI_LSB = ADDR_W - PIN_W;

  logic [PIN_W-1:0]  srcAlt;
  logic [PIN_W-1:0]  dataOut;
  logic [PIN_W-1:0]  dirReg;
  logic [PIN_W-1:0]  driveReg;
  logic [PIN_W-1:0]  altKind;
  logic              addrHigh;
  logic [ADDR_W-1:0] heldAddr;
  logic [ADDR_W-1:0] curAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcAlt   <= '0;
      dataOut  <= '0;
      dirReg   <= '0;
      driveReg <= '0;
      altKind  <= '0;
      addrHigh <= 1'b0;
    end else begin
      if (stb.wrSrcAlt)  srcAlt   <= wrData;
      if (stb.wrDataOut) dataOut  <= wrData;
      if (stb.wrDir)     dirReg   <= wrData;
      if (stb.wrDrive)   driveReg <= wrData;
      if (stb.wrAltKind) altKind  <= wrData;
      if (stb.wrAddrCfg) addrHigh <= wrData[0];
    end
  end

  // Address hold: follows the bus at each edge while the strobe is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           heldAddr <= '0;
    else if (stb.aleOpen) heldAddr <= addrBus;
  end

  assign curAddr  = stb.aleOpen ? addrBus : heldAddr;
  assign addrByte = addrHigh ? curAddr[HI_LSB +: PIN_W] : curAddr[PIN_W-1:0];
  assign driveCfg = driveReg;

  genvar gi;
  generate
    for (gi = 0; gi < PIN_W; gi++) begin : g_pin
      pinport_slice #(.OD_OK(gi >= OD_LO)) i_slice (
        .useAlt   (srcAlt[gi]),
        .altIsAddr(altKind[gi]),
        .mcuBit   (dataOut[gi]),
        .addrBit  (addrByte[gi]),
        .mcellBit (mcellOut[gi]),
        .dirBit   (dirReg[gi]),
        .ptermBit (ptermOe[gi]),
        .driveBit (driveReg[gi]),
        .outBit   (padOut[gi]),
        .oeBit    (padOe[gi]),
        .fastBit  (padFastSlew[gi])
      );
    end
  endgenerate

  always_comb begin
    unique case (stb.rdSel)
      OFS_PIN_IN:   rdData = padIn;
      OFS_SRC_ALT:  rdData = srcAlt;
      OFS_DATA_OUT: rdData = dataOut;
      OFS_DIR:      rdData = dirReg;
      OFS_DRIVE:    rdData = driveReg;
      OFS_EN_OUT:   rdData = padOe;
      OFS_ALT_KIND: rdData = altKind;
      OFS_ADDR_CFG: rdData = {{(PIN_W-1){1'b0}}, addrHigh};
      default:      rdData = '0;
    endcase
  end

endmodule

// File: rtl/pinport_top.sv
module pinport_top
  import pinport_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        regSel,
  input  logic              regWrEn,
  input  logic [PIN_W-1:0]  regWrData,
  output logic [PIN_W-1:0]  regRdData,
  input  logic              ale,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [PIN_W-1:0]  mcellOut,
  input  logic [PIN_W-1:0]  ptermOe,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padOe,
  output logic [PIN_W-1:0]  padFastSlew,
  output logic [PIN_W-1:0]  inMcell
);

  portStb_t         stb;
  logic [PIN_W-1:0] driveCfg;
  logic [PIN_W-1:0] addrByte;

  pinport_ctrl i_ctrl (
    .regSel (regSel),
    .regWrEn(regWrEn),
    .ale    (ale),
    .stb    (stb)
  );

  pinport_dpath #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) i_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .wrData     (regWrData),
    .addrBus    (addrBus),
    .mcellOut   (mcellOut),
    .ptermOe    (ptermOe),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .padFastSlew(padFastSlew),
    .rdData     (regRdData),
    .driveCfg   (driveCfg),
    .addrByte   (addrByte)
  );

  assign inMcell = padIn;

endmodule

// File: rtl/pinport_chk.sv
module pinport_chk #(
  parameter int PIN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       regSel,
  input logic             regWrEn,
  input logic             ale,
  input logic [PIN_W-1:0] regRdData,
  input logic [PIN_W-1:0] padIn,
  input logic [PIN_W-1:0] padOut,
  input logic [PIN_W-1:0] padOe,
  input logic [PIN_W-1:0] padFastSlew,
  input logic [PIN_W-1:0] inMcell,
  input logic [PIN_W-1:0] driveCfg,
  input logic [PIN_W-1:0] addrByte
);

  localparam int             OD_LO   = PIN_W / 2;
  localparam logic [PIN_W-1:0] UP_MASK = {{(PIN_W-OD_LO){1'b1}}, {OD_LO{1'b0}}};

  // R1: the first sampled cycle out of reset has every pin released
  assert_reset_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (padOe == '0));

  // R5: with the strobe low and no config write, the presented byte holds
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!ale) && !$past(regWrEn)) |-> $stable(addrByte));

  // R7: an enabled open-drain pin never drives a high level
  assert_od_drives_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((driveCfg & padOe & padOut & UP_MASK) == '0));

  // R8: the upper half never requests fast slew
  assert_no_slew_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((padFastSlew & UP_MASK) == '0));

  // R9: reading the enable offset mirrors the pad enables
  assert_en_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (regSel == 3'd5) |-> (regRdData == padOe));

  // R12: input macrocells see the pin levels
  assert_in_route_R12: assert property (@(posedge clk) disable iff (!rst_n)
    inMcell == padIn);

endmodule

bind pinport_top pinport_chk #(.PIN_W(PIN_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .regSel     (regSel),
  .regWrEn    (regWrEn),
  .ale        (ale),
  .regRdData  (regRdData),
  .padIn      (padIn),
  .padOut     (padOut),
  .padOe      (padOe),
  .padFastSlew(padFastSlew),
  .inMcell    (inMcell),
  .driveCfg   (driveCfg),
  .addrByte   (addrByte)
);

// File: tb/test_pinport_top.sv
`timescale 1ns/1ps
module test_pinport_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        ale = 1'b0;
  logic [15:0] addrBus = '0;
  logic [7:0]  mcellOut = '0;
  logic [7:0]  ptermOe = '0;
  logic [7:0]  padIn;
  logic [7:0]  padOut, padOe, padFastSlew, inMcell;
  logic [7:0]  extLevel = '0;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // pins: driven value when enabled, external level otherwise
  assign padIn = (padOe & padOut) | (~padOe & extLevel);

  pinport_top i_pinport_top (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .ale(ale), .addrBus(addrBus),
    .mcellOut(mcellOut), .ptermOe(ptermOe), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .padFastSlew(padFastSlew), .inMcell(inMcell)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  mReg [8];
  logic [15:0] mHeld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) mReg[k] = 8'h00;
      mHeld = 16'h0000;
    end else begin
      if (regWrEn && regSel != 3'd0 && regSel != 3'd5)
        mReg[regSel] = (regSel == 3'd7) ? (regWrData & 8'h01) : regWrData;
      if (ale) mHeld = addrBus;
    end
  end

  logic [7:0] eOut, eOe, eSlew, ePin, eRd;

  always_comb begin
    logic [15:0] a;
    logic [7:0]  byteSel;
    a       = ale ? addrBus : mHeld;
    byteSel = mReg[7][0] ? a[15:8] : a[7:0];
    for (int i = 0; i < 8; i++) begin
      logic alt, kind, v, oe;
      alt  = mReg[1][i];
      kind = mReg[6][i];
      v    = alt ? (kind ? byteSel[i] : mcellOut[i]) : mReg[2][i];
      oe   = (alt && !kind) ? ptermOe[i] : mReg[3][i];
      if (i >= 4 && mReg[4][i] && v) oe = 1'b0;
      eOut[i]  = v;
      eOe[i]   = oe;
      eSlew[i] = (i < 4) ? mReg[4][i] : 1'b0;
    end
    ePin = (eOe & eOut) | (~eOe & extLevel);
    if (regSel == 3'd0)      eRd = ePin;
    else if (regSel == 3'd5) eRd = eOe;
    else                     eRd = mReg[regSel];
  end

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R2", "padOut", padOut, eOut);
      cmp("R7", "padOe", padOe, eOe);
      cmp("R8", "padFastSlew", padFastSlew, eSlew);
      cmp("R12", "inMcell", inMcell, ePin);
      cmp("R10", "regRdData", regRdData, eRd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regSel = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(string tag, input logic [2:0] a, input logic [7:0] exp);
    regSel = a;
    @(negedge clk);
    cmp(tag, "read", regRdData, exp);
    tick();
  endtask

  task automatic padChk(string tag, input logic [7:0] expOut, input logic [7:0] expOe);
    @(negedge clk);
    cmp(tag, "padOut", padOut, expOut);
    cmp(tag, "padOe", padOe, expOe);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    @(negedge clk); cmp("R1", "padOe", padOe, 8'h00); tick();
    for (int k = 1; k < 8; k++) rdChk("R1", 3'(k), 8'h00);

    // R2: data-out source with direction enable
    wr(3'd2, 8'hA5); wr(3'd3, 8'hFF);
    padChk("R2", 8'hA5, 8'hFF);

    // R10: readback
    rdChk("R10", 3'd2, 8'hA5);
    rdChk("R10", 3'd3, 8'hFF);
    wr(3'd7, 8'hFF); rdChk("R10", 3'd7, 8'h01); wr(3'd7, 8'h00);
    extLevel = 8'h3C;
    rdChk("R10", 3'd0, 8'hA5);

    // R11: writes to read-only offsets ignored
    wr(3'd0, 8'h00); wr(3'd5, 8'h00);
    rdChk("R11", 3'd2, 8'hA5);
    rdChk("R11", 3'd5, 8'hFF);
    padChk("R11", 8'hA5, 8'hFF);

    // R3 / R5: address source, transparent then held
    addrBus = 16'h1234; ale = 1'b1;
    wr(3'd6, 8'hFF); wr(3'd1, 8'hFF);
    padChk("R3", 8'h34, 8'hFF);
    addrBus = 16'hABCD;
    padChk("R5", 8'hCD, 8'hFF);
    ale = 1'b0; tick();
    addrBus = 16'h5555;
    padChk("R5", 8'hCD, 8'hFF);
    wr(3'd3, 8'h0F);
    padChk("R3", 8'hCD, 8'h0F);
    wr(3'd3, 8'hFF);

    // R6: high byte selection
    wr(3'd7, 8'h01);
    padChk("R6", 8'hAB, 8'hFF);
    wr(3'd7, 8'h00);

    // R4: macrocell source and product-term enable
    wr(3'd6, 8'h00); mcellOut = 8'h3C; ptermOe = 8'hF0;
    padChk("R4", 8'h3C, 8'hF0);

    // R7 / R9: open-drain on upper nibble
    wr(3'd1, 8'h00); wr(3'd2, 8'h5A); wr(3'd4, 8'hF0);
    padChk("R7", 8'h5A, 8'hAF);
    rdChk("R9", 3'd5, 8'hAF);
    extLevel = 8'hFF;
    @(negedge clk); cmp("R12", "inMcell", inMcell, 8'h5A); tick();

    // R8: slew on lower nibble only
    wr(3'd4, 8'h0F);
    @(negedge clk); cmp("R8", "padFastSlew", padFastSlew, 8'h0F);
    cmp("R7", "padOe", padOe, 8'hFF); tick();
    wr(3'd4, 8'hFF);
    @(negedge clk); cmp("R8", "padFastSlew", padFastSlew, 8'h0F);
    cmp("R7", "padOe", padOe, 8'hAF); tick();

    // mixed random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      regWrEn   = ($urandom % 3) == 0;
      regSel    = 3'($urandom);
      regWrData = 8'($urandom);
      ale       = ($urandom % 4) == 0;
      addrBus   = 16'($urandom);
      mcellOut  = 8'($urandom);
      ptermOe   = 8'($urandom);
      extLevel  = 8'($urandom);
      tick();
    end
    regWrEn = 1'b0;
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule